// File: doc/BRIEF.md
# Interrupt Status and Acknowledge Block

This block is the interrupt front end of a backplane bus slave. Up to eight internal event sources each raise a one-cycle pulse. Each pulse sets its own sticky pending bit, and the block drives an active-high interrupt request line for as long as any pending bit stays set. The pending bits and the board's logical address are packed into one 16-bit status/ID word.

Software can read that word in two ways. A plain read of the status register leaves the state untouched. An interrupt acknowledge cycle returns the same word and clears every pending bit. Individual bits can also be cleared by writing ones to a second register, the reset register. Clearing a bit never masks its source: the next pulse from that source sets the bit again.

There is no streaming data path. Every pin is a plain control or status strobe sampled on the rising clock edge, so no back-pressure applies. Read data is combinational in the cycle of the strobe.

Top module: `irq_status_ack`

## Requirements
- R1: While `bus_rd_i` is high with `bus_sel_i`=0 (status register), `bus_rdata_o` is combinationally {pending[7:0], laddr_i[7:0]}. Pending bit n sits at bit 8+n. The address is taken live from `laddr_i`. With no read and no acknowledge, `bus_rdata_o` is 0, and a read of the reset register (`bus_sel_i`=1) also returns 0.
- R2: A high `cause_i[n]` at a clock edge sets pending bit n. The bit then stays set until it is cleared.
- R3: A status register read changes neither the pending bits nor `irq_o`.
- R4: While `iack_i` is high, `bus_rdata_o` carries the status/ID word (format of R1) in that cycle. At the following edge all pending bits are cleared.
- R5: A write with `bus_sel_i`=1 clears pending bit n when `bus_wdata_i[8+n]` is 1. Zero bits and `bus_wdata_i[7:0]` have no effect. A write with `bus_sel_i`=0 has no effect.
- R6: A bit cleared by a write or by an acknowledge is set again by a later pulse from its source.
- R7: If a source pulse and a clear of the same bit (write or acknowledge) arrive in the same cycle, the bit ends up set.
- R8: `irq_o` is registered. It is high in the cycle after any pending bit is set, and low in the cycle after all pending bits are clear.
- R9: During and directly after reset, all pending bits are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_i | input | 8 | One pulse per source; bit n sets pending bit n |
| laddr_i | input | 8 | Board logical address, static |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 = status, 1 = reset |
| bus_wdata_i | input | 16 | Write data; bits 15..8 are the clear mask |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| bus_rdata_o | output | 16 | Status/ID word on a status read or acknowledge, else 0 |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A behavioural model of the pending set and the request line is compared with the design's read word and `irq_o` in every cycle. Directed phases separate three things:
- a side-effect-free read from an acknowledge, because a read is followed by a second read that must return the same word;
- masked clears from ignored ones, through write data whose low byte and zero bits are non-zero noise, and through writes to the status register;
- pulse-versus-clear collisions, for both the write path and the acknowledge path.

A long random phase then mixes pulses, reads, writes, acknowledges and a changing address. Any wrong bit position, wrong precedence or wrong IRQ latency shows up as a word or line mismatch.

// File: rtl/irq_sa_pkg.sv
package irq_sa_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_RESET  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_latch.sv
module irq_cause_latch #(
  parameter int N_CAUSE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] set_i,
  input  logic [N_CAUSE-1:0] clr_i,
  output logic [N_CAUSE-1:0] pend_o
);
  for (genvar g = 0; g < N_CAUSE; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= set_i[g] | (bit_q & ~clr_i[g]);
    end
    assign pend_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_sa_pkg::*;
#(
  parameter int N_CAUSE = 8,
  parameter int LA_W    = 8,
  localparam int DW     = N_CAUSE + LA_W
) (
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               sel_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               iack_i,
  input  logic [N_CAUSE-1:0] pend_i,
  input  logic [LA_W-1:0]    laddr_i,
  output logic [N_CAUSE-1:0] clr_o,
  output logic [DW-1:0]      rdata_o
);
  logic sel_reset, rd_hit;

  always_comb begin
    sel_reset = (reg_sel_e'(sel_i) == SEL_RESET);
    rd_hit    = iack_i || (rd_i && !sel_reset);
    if (iack_i)                clr_o = '1;
    else if (wr_i && sel_reset) clr_o = wdata_i[DW-1:LA_W];
    else                       clr_o = '0;
    rdata_o = rd_hit ? {pend_i, laddr_i} : '0;
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int N_CAUSE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] pend_i,
  output logic               irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pend_i;
  end
endmodule

// File: rtl/irq_status_ack.sv
module irq_status_ack
  import irq_sa_pkg::*;
#(
  parameter int N_CAUSE = 8,
  parameter int LA_W    = 8,
  localparam int DW     = N_CAUSE + LA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] cause_i,
  input  logic [LA_W-1:0]    laddr_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic               bus_sel_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic               iack_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o
);
  logic [N_CAUSE-1:0] pend, clr;

  irq_bus_decode #(.N_CAUSE(N_CAUSE), .LA_W(LA_W)) u_dec (
    .rd_i(bus_rd_i), .wr_i(bus_wr_i), .sel_i(bus_sel_i),
    .wdata_i(bus_wdata_i), .iack_i(iack_i), .pend_i(pend),
    .laddr_i(laddr_i), .clr_o(clr), .rdata_o(bus_rdata_o)
  );

  irq_cause_latch #(.N_CAUSE(N_CAUSE)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(cause_i), .clr_i(clr), .pend_o(pend)
  );

  irq_line_drv #(.N_CAUSE(N_CAUSE)) u_irq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .irq_o(irq_o)
  );

  AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_sel_i) |-> (bus_rdata_o[LA_W-1:0] == laddr_i)); // R1
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i != '0) |=> ((pend & $past(cause_i)) == $past(cause_i))); // R7
  AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && !iack_i && cause_i == '0) |=> $stable(pend)); // R3
  AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && cause_i == '0) |=> (pend == '0)); // R4
  AST_W1C_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_sel_i && !iack_i && cause_i == '0)
      |=> ((pend & $past(bus_wdata_i[DW-1:LA_W])) == '0)); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> irq_o); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq_o); // R8
endmodule

// File: tb/irq_status_ack_tb.sv
module irq_status_ack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cause = '0, laddr = 8'h5A;
  logic        rd = 0, wr = 0, sel = 0, iack = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] st_m = '0;
  logic       irq_m = 0;

  always #4 clk = ~clk;

  irq_status_ack dut_i (
    .clk(clk), .rst_n(rst_n), .cause_i(cause), .laddr_i(laddr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_sel_i(sel), .bus_wdata_i(wdata),
    .iack_i(iack), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check outputs, update model at posedge
  task automatic step(input logic [7:0] p, input logic r, input logic w, input logic s,
                      input logic [15:0] wd, input logic a, input string tag);
    logic [15:0] exp_rd;
    logic [7:0]  clr;
    @(negedge clk);
    cause = p; rd = r; wr = w; sel = s; wdata = wd; iack = a;
    #1;
    exp_rd = (a || (r && !s)) ? {st_m, laddr} : 16'h0;
    chk({tag, " rdata (R1/R4)"}, rdata, exp_rd);
    chk("R8 irq", {15'h0, irq}, {15'h0, irq_m});
    clr = a ? 8'hFF : ((w && s) ? wd[15:8] : 8'h00);
    @(posedge clk);
    irq_m = (st_m != 0);
    st_m  = (st_m & ~clr) | p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h00, 0, 0, 0, 16'h0, 0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R9 irq in reset", {15'h0, irq}, 16'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9: nothing pending after reset
    step(8'h00, 1, 0, 0, 16'h0, 0, "R9");
    idle(1);
    // R2: pulses set sticky bits; R8 latency
    step(8'h01, 0, 0, 0, 16'h0, 0, "R2");
    step(8'h00, 0, 0, 0, 16'h0, 0, "R8");
    step(8'h80, 1, 0, 0, 16'h0, 0, "R2");
    // R3: repeated reads see the same word
    step(8'h00, 1, 0, 0, 16'h0, 0, "R3");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R3");
    // R1: live address change
    laddr = 8'hC3;
    step(8'h00, 1, 0, 0, 16'h0, 0, "R1");
    step(8'h00, 1, 0, 1, 16'h0, 0, "R1 reset reg read");
    // R5: write to status register ignored, low byte ignored
    step(8'h00, 0, 1, 0, 16'hFFFF, 0, "R5 status write");
    step(8'h00, 0, 1, 1, 16'h00FF, 0, "R5 low byte");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R5");
    step(8'h00, 0, 1, 1, 16'h0100, 0, "R5 clear bit0");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R5");
    step(8'h00, 0, 1, 1, 16'h8000, 0, "R5 clear bit7");
    idle(2);   // R8 falls
    step(8'h00, 1, 0, 0, 16'h0, 0, "R8");
    // R6: set again after clear
    step(8'h81, 0, 0, 0, 16'h0, 0, "R6");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R6");
    // R7: pulse vs W1C collision
    step(8'h01, 0, 1, 1, 16'h8100, 0, "R7 w1c");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R7");
    // R4: iack returns word and clears
    step(8'h24, 0, 0, 0, 16'h0, 0, "R4");
    step(8'h00, 0, 0, 0, 16'h0, 1, "R4 iack");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R4 after");
    idle(2);
    // R7: pulse vs iack collision
    step(8'h10, 0, 0, 0, 16'h0, 0, "R7");
    step(8'h02, 0, 0, 0, 16'h0, 1, "R7 iack");
    step(8'h00, 1, 0, 0, 16'h0, 0, "R7");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] p;
      int op;
      p  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      op = $urandom % 8;
      if (i % 97 == 0) laddr = 8'($urandom);
      step(p, op < 3, op == 3 || op == 4, op == 4 || op == 1, 16'($urandom), op == 5,
           "random");
    end
    idle(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule